// File: doc/BRIEF.md
# Bus Cycle Timeout Responder

This block watches every transfer on an asynchronous parallel backplane bus. That includes interrupt acknowledge cycles, because it looks only at the address strobe and the two data strobes. It steps in when no other slave ends a transfer within a set time. Depending on its mode inputs, it then ends the transfer with a generated acknowledge or with a generated bus error. On a read it can first put a stored data word on the bus, so that software reads a known value back. When hold-on-error is set, it asks the signal-capture logic to freeze once the terminated transfer has finished. It keeps that halt request until a release input is pulsed.

All bus inputs arrive already synchronised and active high. The timer counts a one-microsecond tick, which is made by dividing the clock, so every timeout is an exact number of clock periods. The base timeout is four microseconds. When the short-access mode is enabled, a two-bit select can shorten it. A front-panel style indicator output stays lit for a programmable stretch after each generated acknowledge, and stays lit without a break while the block is halted.

The control is one state machine with these states:
- IDLE waits for a cycle.
- TIMING counts.
- LEAD drives data ahead of the acknowledge.
- ACK_DATA and ACK drive the acknowledge.
- ERR drives the bus error.
- DRAIN waits out a cycle the block does not terminate.
- HALTED holds the halt request.

The transitions are:
- cycle start: IDLE to TIMING.
- abort: TIMING to IDLE.
- foreign end: TIMING to DRAIN.
- expiry: TIMING to LEAD, ACK, ERR or DRAIN.
- lead done: LEAD to ACK_DATA.
- strobes negated: ACK, ACK_DATA or DRAIN to IDLE; ACK, ACK_DATA or ERR to HALTED.
- release: HALTED to IDLE.

Top module: `bus_timeout_responder`

## Requirements
- R1: After reset, all drive outputs, the halt request and the indicator are low.
- R2: The timeout counts from the first clock edge that sees the address strobe and at least one data strobe asserted. It lasts TICKS_PER_US times L clock cycles. L is 4 while short mode is off, whatever the select input says. With short mode on, L is 4, 3, 2 or 1 for select values 0, 1, 2 or 3.
- R3: With acknowledge mode on, the acknowledge drive rises at timeout on reads and writes alike, provided data-enable does not apply.
- R4: With acknowledge mode and data-enable both on, a read that times out raises the data output enable at timeout, and the acknowledge follows LEAD_CYCLES cycles later. In every other case, that is acknowledge mode off or a write, data-enable has no effect: the output enable stays low.
- R5: With acknowledge mode off and hold-on-error on, the bus-error drive rises at timeout.
- R6: With acknowledge mode and hold-on-error both off, a timeout drives nothing.
- R7: A generated acknowledge or bus error stays driven until both data strobes are negated, and is gone in the next cycle. Each transfer gets at most one.
- R8: If another slave's acknowledge or bus error is seen before timeout, the block drives nothing for that transfer, and it does not halt.
- R9: If the strobes negate before timeout, the count is discarded. The next cycle is timed in full again.
- R10: With hold-on-error on, the halt request rises once a terminated transfer ends. While halted, the block drives nothing on new transfers. The halt request stays up until the release input is pulsed.
- R11: The indicator is high for exactly LED_US times TICKS_PER_US cycles, starting in the cycle the generated acknowledge rises. It is also high throughout HALTED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_i | input | 1 | Address strobe, asserted high |
| ds0_i | input | 1 | Data strobe 0, asserted high |
| ds1_i | input | 1 | Data strobe 1, asserted high |
| write_i | input | 1 | High for a write transfer |
| ext_dtack_i | input | 1 | Acknowledge seen from another slave |
| ext_berr_i | input | 1 | Bus error seen from another slave |
| ack_mode_i | input | 1 | Terminate timed-out cycles with an acknowledge |
| data_en_i | input | 1 | Drive the stored data word on timed-out reads |
| hold_err_i | input | 1 | Halt after a terminated cycle |
| short_en_i | input | 1 | Allow the shortened timeouts |
| tsel_i | input | 2 | Timeout select used in short mode |
| halt_release_i | input | 1 | Leave HALTED |
| dtack_drv_o | output | 1 | Drive the acknowledge line |
| berr_drv_o | output | 1 | Drive the bus-error line |
| data_oe_o | output | 1 | Enable the stored data word onto the bus |
| halt_req_o | output | 1 | Freeze request to the capture logic |
| ack_led_o | output | 1 | Stretched acknowledge-mode indicator |

## Verification
The assertions assume three things about the inputs:
- The mode inputs, the select, short mode and the write line stay steady for the whole of a transfer.
- The strobes stay asserted until the generated termination has been seen.
- The inputs have already been synchronised.

The bench keeps to these assumptions. It changes configuration only at falling edges while the bus is idle, and it negates the strobes only after it has sampled the termination. It sweeps every combination of short mode, select, direction, acknowledge mode, data-enable and hold-on-error. Directed runs then cover foreign terminations, aborted cycles and the indicator stretch.

// File: rtl/bto_pkg.sv
package bto_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TIMING,
        ST_LEAD,
        ST_ACK_DATA,
        ST_ACK,
        ST_ERR,
        ST_DRAIN,
        ST_HALTED
    } bto_state_e;
endpackage

// File: rtl/bto_limit_sel.sv
module bto_limit_sel #(
    parameter int BASE_US = 4,
    parameter int UW      = 3
) (
    input  logic          short_en_i,
    input  logic [1:0]    tsel_i,
    output logic [UW-1:0] limit_o
);
    // Short mode shortens the base timeout by the select value.
    always_comb begin
        if (short_en_i) limit_o = UW'(BASE_US) - UW'(tsel_i);
        else            limit_o = UW'(BASE_US);
    end
endmodule

// File: rtl/bto_us_timer.sv
module bto_us_timer #(
    parameter int TICKS_PER_US = 50,
    parameter int UW           = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [UW-1:0] limit_i,
    output logic          expired_o
);
    logic          tick;
    logic [UW-1:0] us_q;

    generate
        if (TICKS_PER_US > 1) begin : g_prescale
            localparam int PW = $clog2(TICKS_PER_US);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  pre_q <= '0;
                else if (!run_i)             pre_q <= '0;
                else if (pre_q == PW'(TICKS_PER_US - 1)) pre_q <= '0;
                else                         pre_q <= pre_q + 1'b1;
            end
            assign tick = run_i && (pre_q == PW'(TICKS_PER_US - 1));
        end else begin : g_direct
            assign tick = run_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      us_q <= '0;
        else if (!run_i) us_q <= '0;
        else if (tick)   us_q <= us_q + 1'b1;
    end

    assign expired_o = tick && (us_q == limit_i - UW'(1));

    assert_us_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (us_q < limit_i));
endmodule

// File: rtl/bto_led_stretch.sv
module bto_led_stretch #(
    parameter int HOLD_CYCLES = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic steady_i,
    output logic led_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (fire_i)      cnt_q <= CW'(HOLD_CYCLES);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign led_o = (cnt_q != '0) || steady_i;

    assert_led_on_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> led_o);
endmodule

// File: rtl/bto_fsm.sv
module bto_fsm
    import bto_pkg::*;
#(
    parameter int LEAD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_i,
    input  logic ds0_i,
    input  logic ds1_i,
    input  logic write_i,
    input  logic ext_dtack_i,
    input  logic ext_berr_i,
    input  logic ack_mode_i,
    input  logic data_en_i,
    input  logic hold_err_i,
    input  logic halt_release_i,
    input  logic expired_i,
    output logic run_o,
    output logic fire_ack_o,
    output logic dtack_drv_o,
    output logic berr_drv_o,
    output logic data_oe_o,
    output logic halt_req_o
);
    localparam int LW = $clog2(LEAD_CYCLES + 1);

    bto_state_e    state_q, state_d;
    logic          halt_pend_q;
    logic [LW-1:0] lead_q;
    logic          strobe, cyc;

    assign strobe = ds0_i || ds1_i;
    assign cyc    = as_i && strobe;

    // State register and per-state counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            halt_pend_q <= 1'b0;
            lead_q      <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_TIMING && expired_i) halt_pend_q <= hold_err_i;
            else if (state_q == ST_IDLE)           halt_pend_q <= 1'b0;
            if (state_q == ST_LEAD) lead_q <= lead_q + 1'b1;
            else                    lead_q <= '0;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cyc) state_d = ST_TIMING;
            ST_TIMING: begin
                if (ext_dtack_i || ext_berr_i) state_d = ST_DRAIN;
                else if (!cyc)                 state_d = ST_IDLE;
                else if (expired_i) begin
                    if (ack_mode_i)      state_d = (!write_i && data_en_i) ? ST_LEAD : ST_ACK;
                    else if (hold_err_i) state_d = ST_ERR;
                    else                 state_d = ST_DRAIN;
                end
            end
            ST_LEAD:     if (lead_q == LW'(LEAD_CYCLES - 1)) state_d = ST_ACK_DATA;
            ST_ACK_DATA: if (!strobe) state_d = halt_pend_q ? ST_HALTED : ST_IDLE;
            ST_ACK:      if (!strobe) state_d = halt_pend_q ? ST_HALTED : ST_IDLE;
            ST_ERR:      if (!strobe) state_d = ST_HALTED;
            ST_DRAIN:    if (!strobe) state_d = ST_IDLE;
            ST_HALTED:   if (halt_release_i) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        run_o       = 1'b0;
        dtack_drv_o = 1'b0;
        berr_drv_o  = 1'b0;
        data_oe_o   = 1'b0;
        halt_req_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_TIMING:   run_o = 1'b1;
            ST_LEAD:     data_oe_o = 1'b1;
            ST_ACK_DATA: begin data_oe_o = 1'b1; dtack_drv_o = 1'b1; end
            ST_ACK:      dtack_drv_o = 1'b1;
            ST_ERR:      berr_drv_o = 1'b1;
            ST_DRAIN:    ;
            ST_HALTED:   halt_req_o = 1'b1;
            default:     ;
        endcase
    end

    assign fire_ack_o = (state_d == ST_ACK      && state_q != ST_ACK) ||
                        (state_d == ST_ACK_DATA && state_q != ST_ACK_DATA);

    assert_ack_in_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_drv_o) |-> (as_i && (ds0_i || ds1_i)));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dtack_drv_o || berr_drv_o) && !(ds0_i || ds1_i)) |=> (!dtack_drv_o && !berr_drv_o));

    assert_err_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_drv_o && !(ds0_i || ds1_i)) |=> halt_req_o);

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req_o && !halt_release_i) |=> halt_req_o);

    assert_oe_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_o) |-> (ack_mode_i && data_en_i && !write_i));

    assert_foreign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && (ext_dtack_i || ext_berr_i)) |=> (!dtack_drv_o && !berr_drv_o && !data_oe_o));
endmodule

// File: rtl/bus_timeout_responder.sv
module bus_timeout_responder #(
    parameter int TICKS_PER_US = 50,
    parameter int BASE_US      = 4,
    parameter int LEAD_CYCLES  = 2,
    parameter int LED_US       = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_i,
    input  logic       ds0_i,
    input  logic       ds1_i,
    input  logic       write_i,
    input  logic       ext_dtack_i,
    input  logic       ext_berr_i,
    input  logic       ack_mode_i,
    input  logic       data_en_i,
    input  logic       hold_err_i,
    input  logic       short_en_i,
    input  logic [1:0] tsel_i,
    input  logic       halt_release_i,
    output logic       dtack_drv_o,
    output logic       berr_drv_o,
    output logic       data_oe_o,
    output logic       halt_req_o,
    output logic       ack_led_o
);
    localparam int UW          = $clog2(BASE_US + 1);
    localparam int HOLD_CYCLES = LED_US * TICKS_PER_US;

    logic [UW-1:0] limit_us;
    logic          run, expired, fire_ack;

    bto_limit_sel #(.BASE_US(BASE_US), .UW(UW)) u_limit (
        .short_en_i(short_en_i),
        .tsel_i    (tsel_i),
        .limit_o   (limit_us)
    );

    bto_us_timer #(.TICKS_PER_US(TICKS_PER_US), .UW(UW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .limit_i  (limit_us),
        .expired_o(expired)
    );

    bto_fsm #(.LEAD_CYCLES(LEAD_CYCLES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .as_i          (as_i),
        .ds0_i         (ds0_i),
        .ds1_i         (ds1_i),
        .write_i       (write_i),
        .ext_dtack_i   (ext_dtack_i),
        .ext_berr_i    (ext_berr_i),
        .ack_mode_i    (ack_mode_i),
        .data_en_i     (data_en_i),
        .hold_err_i    (hold_err_i),
        .halt_release_i(halt_release_i),
        .expired_i     (expired),
        .run_o         (run),
        .fire_ack_o    (fire_ack),
        .dtack_drv_o   (dtack_drv_o),
        .berr_drv_o    (berr_drv_o),
        .data_oe_o     (data_oe_o),
        .halt_req_o    (halt_req_o)
    );

    bto_led_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_led (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire_ack),
        .steady_i(halt_req_o),
        .led_o   (ack_led_o)
    );
endmodule

// File: tb/bus_timeout_responder_test.sv
module bus_timeout_responder_test;
    localparam int CLK_PERIOD = 10;
    localparam int TPU        = 4;
    localparam int LEAD       = 2;
    localparam int LEDUS      = 10;
    localparam int LED_LEN    = LEDUS * TPU;

    logic clk = 1'b0, rst_n = 1'b0;
    logic as_i = 0, ds0_i = 0, ds1_i = 0, write_i = 0, ext_dtack_i = 0, ext_berr_i = 0;
    logic ack_mode_i = 0, data_en_i = 0, hold_err_i = 0, short_en_i = 0, halt_release_i = 0;
    logic [1:0] tsel_i = 2'd0;
    logic dtack_drv_o, berr_drv_o, data_oe_o, halt_req_o, ack_led_o;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_timeout_responder #(.TICKS_PER_US(TPU), .BASE_US(4), .LEAD_CYCLES(LEAD), .LED_US(LEDUS)) uut (
        .clk(clk), .rst_n(rst_n), .as_i(as_i), .ds0_i(ds0_i), .ds1_i(ds1_i), .write_i(write_i),
        .ext_dtack_i(ext_dtack_i), .ext_berr_i(ext_berr_i), .ack_mode_i(ack_mode_i),
        .data_en_i(data_en_i), .hold_err_i(hold_err_i), .short_en_i(short_en_i), .tsel_i(tsel_i),
        .halt_release_i(halt_release_i), .dtack_drv_o(dtack_drv_o), .berr_drv_o(berr_drv_o),
        .data_oe_o(data_oe_o), .halt_req_o(halt_req_o), .ack_led_o(ack_led_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        as_i = 0; ds0_i = 0; ds1_i = 0;
    endtask

    task automatic release_halt();
        halt_release_i = 1;
        @(negedge clk);
        halt_release_i = 0;
    endtask

    // One swept transfer; expected times computed from the requirements
    task automatic sweep_run(input bit sh, input bit [1:0] ts, input bit wr,
                             input bit ack, input bit den, input bit hold);
        int t_d = 0, t_b = 0, t_o = 0, lim, t0, exp_d, exp_b, exp_o, any;
        string tag;
        short_en_i = sh; tsel_i = ts; write_i = wr;
        ack_mode_i = ack; data_en_i = den; hold_err_i = hold;
        as_i = 1; ds0_i = 1; ds1_i = ts[0];
        for (int s = 1; s <= 40; s++) begin
            @(negedge clk);
            if (dtack_drv_o && t_d == 0) t_d = s;
            if (berr_drv_o  && t_b == 0) t_b = s;
            if (data_oe_o   && t_o == 0) t_o = s;
        end
        lim   = sh ? 4 - int'(ts) : 4;
        t0    = lim * TPU + 1;
        exp_o = (ack && !wr && den) ? t0 : 0;
        exp_d = ack ? ((exp_o != 0) ? t0 + LEAD : t0) : 0;
        exp_b = (!ack && hold) ? t0 : 0;
        tag   = ack ? ((exp_o != 0) ? "R4" : "R3") : (hold ? "R5" : "R6");
        chk(t_d == exp_d, {tag, " R2 ack time"}, t_d, exp_d);
        chk(t_b == exp_b, {tag, " R2 berr time"}, t_b, exp_b);
        chk(t_o == exp_o, "R4 data enable time", t_o, exp_o);
        chk(dtack_drv_o == (exp_d != 0) && berr_drv_o == (exp_b != 0), "R7 held until strobes drop",
            int'({dtack_drv_o, berr_drv_o}), int'({exp_d != 0, exp_b != 0}));
        bus_idle();
        @(negedge clk);
        chk(!dtack_drv_o && !berr_drv_o && !data_oe_o, "R7 released after strobes",
            int'({dtack_drv_o, berr_drv_o, data_oe_o}), 0);
        chk(halt_req_o == hold, "R10 halt after terminated cycle", halt_req_o, hold);
        if (halt_req_o) begin
            any = 0;
            as_i = 1; ds0_i = 1;
            for (int s = 0; s < 30; s++) begin
                @(negedge clk);
                if (dtack_drv_o || berr_drv_o || data_oe_o) any = 1;
            end
            chk(any == 0, "R10 no drive while halted", any, 0);
            bus_idle();
            @(negedge clk);
            chk(halt_req_o == 1, "R10 halt persists", halt_req_o, 1);
            release_halt();
            chk(halt_req_o == 0, "R10 released", halt_req_o, 0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t_d, any, cnt;
        repeat (3) @(negedge clk);
        chk({dtack_drv_o, berr_drv_o, data_oe_o, halt_req_o, ack_led_o} == 5'b0, "R1 in reset",
            int'({dtack_drv_o, berr_drv_o, data_oe_o, halt_req_o, ack_led_o}), 0);
        rst_n = 1;
        @(negedge clk);
        chk({dtack_drv_o, berr_drv_o, data_oe_o, halt_req_o, ack_led_o} == 5'b0, "R1 after reset",
            int'({dtack_drv_o, berr_drv_o, data_oe_o, halt_req_o, ack_led_o}), 0);

        for (int c = 0; c < 128; c++)
            sweep_run(c[6], c[5:4], c[3], c[2], c[1], c[0]);

        // R8: foreign acknowledge or error before timeout
        for (int v = 0; v < 2; v++) begin
            short_en_i = 0; write_i = 0; data_en_i = 1; hold_err_i = 1; ack_mode_i = (v == 0);
            as_i = 1; ds0_i = 1; ds1_i = 1;
            repeat (5) @(negedge clk);
            if (v == 0) ext_dtack_i = 1; else ext_berr_i = 1;
            any = 0;
            for (int s = 0; s < 40; s++) begin
                @(negedge clk);
                if (dtack_drv_o || berr_drv_o || data_oe_o) any = 1;
            end
            chk(any == 0, "R8 no drive after foreign end", any, 0);
            bus_idle(); ext_dtack_i = 0; ext_berr_i = 0;
            @(negedge clk);
            chk(halt_req_o == 0, "R8 no halt", halt_req_o, 0);
        end

        // R9: aborted cycle restarts the count
        ack_mode_i = 1; hold_err_i = 0; data_en_i = 0; short_en_i = 0;
        as_i = 1; ds0_i = 1;
        repeat (10) @(negedge clk);
        bus_idle();
        repeat (2) @(negedge clk);
        as_i = 1; ds1_i = 1;
        t_d = 0;
        for (int s = 1; s <= 40; s++) begin
            @(negedge clk);
            if (dtack_drv_o && t_d == 0) t_d = s;
        end
        chk(t_d == 4 * TPU + 1, "R9 full timeout after abort", t_d, 4 * TPU + 1);
        bus_idle();

        // R11: indicator stretch after a generated acknowledge
        repeat (LED_LEN + 5) @(negedge clk);
        chk(ack_led_o == 0, "R11 indicator idle", ack_led_o, 0);
        short_en_i = 1; tsel_i = 2'd3;
        as_i = 1; ds0_i = 1;
        cnt = 0; t_d = 0;
        for (int s = 1; s <= LED_LEN + 30; s++) begin
            @(negedge clk);
            if (dtack_drv_o && t_d == 0) begin
                t_d = s;
                chk(ack_led_o == 1, "R11 lit with acknowledge", ack_led_o, 1);
            end
            if (ack_led_o) cnt++;
            if (t_d != 0 && s == t_d + 2) bus_idle();
        end
        chk(cnt == LED_LEN, "R11 stretch length", cnt, LED_LEN);

        // R11: steady while halted without any acknowledge
        ack_mode_i = 0; hold_err_i = 1;
        as_i = 1; ds0_i = 1;
        repeat (TPU + 3) @(negedge clk);
        bus_idle();
        any = 0;
        for (int s = 0; s < LED_LEN + 10; s++) begin
            @(negedge clk);
            if (!ack_led_o) any = 1;
        end
        chk(any == 0 && halt_req_o == 1, "R11 steady in halt", any, 0);
        release_halt();
        @(negedge clk);
        chk(ack_led_o == 0, "R11 dark after release", ack_led_o, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule